// File: doc/BRIEF.md
# Quadrature-Phase Fetch/Execute Sequencer

This block paces a small processor's instruction stream. A free-running two-bit phase counter splits each instruction cycle into four input-clock periods, Q1 to Q4, and exports them as one-hot strobes. The block also provides a divided clock-out so the instruction rate can be observed. The block owns the program counter and the instruction register. During each instruction cycle it presents the program counter as the program-memory address. At the same time, the word fetched in the previous cycle sits in the instruction register and is being executed. Fetch and execute therefore overlap.

Data-memory strides are fixed to the phases. The operand read strobe fires in the second phase of an execute cycle and the destination write strobe fires in the fourth. An external decoder inspects the instruction register and raises a branch indication with a target address. The sequencer samples that indication in Q4. When it accepts a branch, the word that was fetched in the same cycle is stale. The sequencer replaces that word with a forced NOP (a bubble) and fetches from the target in the next cycle. A branch therefore costs two instruction cycles and every other instruction costs one.

Top module: `fetch_exec_seq`

## Requirements
- R1: `q_strobe` is one-hot with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3, bit 3 = Q4. It advances one phase per clock, Q1→Q2→Q3→Q4→Q1, and it is at Q1 in the first clock after reset.
- R2: `clk_out` is high during Q1 and Q2 and low during Q3 and Q4.
- R3: `pm_addr` holds the program counter. The counter changes only at the clock edge that ends Q4, so it is stable through Q1–Q4. Without an accepted branch it advances by 2. Bit 0 is always 0.
- R4: `instr_reg` takes the `pm_data` word present during Q4 of the previous instruction cycle, which is the word at the previous `pm_addr`. It holds that word unchanged for the whole execute cycle.
- R5: `dm_rd` is high only in Q2 and `dm_wr` is high only in Q4, each in every execute cycle that is not a bubble. Both are low in bubble cycles.
- R6: A synchronous active-high `rst` sets the program counter to 0, sets `instr_reg` to the NOP code (16'h0000), raises `bubble` and puts the phase at Q1. The first cycle after reset therefore issues no data-memory strobe.
- R7: `br_take` high in Q4 of a non-bubble cycle is an accepted branch. In the next cycle `pm_addr` equals `br_target` with bit 0 cleared, `instr_reg` is the NOP code and `bubble` is high. The cycle after that executes the word at the target.
- R8: `br_take` has no effect when it is high in Q1–Q3, or when it is high during a bubble cycle. In both cases the program counter advances by 2 and the fetched word executes next.
- R9: `bubble` is high exactly during execute cycles whose instruction was forced to NOP, whether by reset or by a branch.
- R10: The program counter wraps modulo 2^21. A sequential step from 21'h1FFFFE gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, four periods per instruction cycle |
| rst | input | 1 | Synchronous active-high reset |
| pm_data | input | 16 | Instruction word read at `pm_addr` |
| br_take | input | 1 | Decoded branch indication for the instruction in `instr_reg` |
| br_target | input | 21 | Branch destination byte address |
| pm_addr | output | 21 | Program-memory byte address (program counter) |
| instr_reg | output | 16 | Instruction being executed this cycle |
| q_strobe | output | 4 | One-hot phase strobes Q1..Q4 |
| clk_out | output | 1 | Clock divided by four, high in Q1 and Q2 |
| dm_rd | output | 1 | Data-memory operand read strobe |
| dm_wr | output | 1 | Data-memory destination write strobe |
| bubble | output | 1 | Current execute cycle is a forced NOP |

## Verification
The bench runs hundreds of instruction cycles against an arithmetic program image in which each word is derived from its own address. This exposes any off-by-one-cycle capture of the instruction register, because the wrong word would show up immediately. Branches are accepted in a regular pattern, and some carry an odd target, which a design that failed to clear bit 0 would fetch misaligned. The bench also raises `br_take` in Q1–Q3 and in every bubble cycle. A design that sampled it in the wrong phase, or let a forced NOP branch, would jump where it should step by 2. One branch lands on the top address to check wrap-around, and a reset in mid-stream checks that the first cycle after it issues no read or write strobe.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_t;

    localparam int unsigned PHASES = 4;

    function automatic logic [PHASES-1:0] phase_onehot(phase_t p);
        return PHASES'(1) << p;
    endfunction

    function automatic phase_t phase_next(phase_t p);
        return phase_t'(p + 2'd1);
    endfunction

endpackage

// File: rtl/phase_gen.sv
module phase_gen
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [PHASES-1:0] strobes,
    output logic              div_clk,
    output logic              last_phase
);
    phase_t ph;

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_Q1;
        else     ph <= phase_next(ph);
    end

    always_comb begin
        strobes    = phase_onehot(ph);
        div_clk    = (ph == PH_Q1) || (ph == PH_Q2);
        last_phase = (ph == PH_Q4);
    end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
    parameter int unsigned PC_W = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic            redirect,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    logic [PC_W-1:0] aligned_target;
    assign aligned_target = {target[PC_W-1:1], 1'b0};

    always_ff @(posedge clk) begin
        if (rst)          pc <= '0;
        else if (advance) pc <= redirect ? aligned_target : pc + STEP;
    end
endmodule

// File: rtl/ir_stage.sv
module ir_stage #(
    parameter int unsigned          IW       = 16,
    parameter logic [IW-1:0]        NOP_CODE = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          squash,
    input  logic [IW-1:0] fetched,
    output logic [IW-1:0] ir,
    output logic          is_bubble
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ir        <= NOP_CODE;
            is_bubble <= 1'b1;
        end else if (capture) begin
            ir        <= squash ? NOP_CODE : fetched;
            is_bubble <= squash;
        end
    end
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq #(
    parameter int unsigned   PC_W     = 21,
    parameter int unsigned   IW       = 16,
    parameter logic [IW-1:0] NOP_CODE = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   pm_data,
    input  logic            br_take,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] pm_addr,
    output logic [IW-1:0]   instr_reg,
    output logic [3:0]      q_strobe,
    output logic            clk_out,
    output logic            dm_rd,
    output logic            dm_wr,
    output logic            bubble
);
    import seq_pkg::*;

    logic cycle_end;
    logic redirect;

    phase_gen u_phase (
        .clk        (clk),
        .rst        (rst),
        .strobes    (q_strobe),
        .div_clk    (clk_out),
        .last_phase (cycle_end)
    );

    // A branch is honoured only in Q4 of a real (non-bubble) execute cycle.
    assign redirect = cycle_end & br_take & ~bubble;

    pc_unit #(.PC_W(PC_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .advance  (cycle_end),
        .redirect (redirect),
        .target   (br_target),
        .pc       (pm_addr)
    );

    ir_stage #(.IW(IW), .NOP_CODE(NOP_CODE)) u_ir (
        .clk       (clk),
        .rst       (rst),
        .capture   (cycle_end),
        .squash    (redirect),
        .fetched   (pm_data),
        .ir        (instr_reg),
        .is_bubble (bubble)
    );

    assign dm_rd = q_strobe[1] & ~bubble;
    assign dm_wr = q_strobe[3] & ~bubble;
endmodule

// File: rtl/fetch_exec_seq_checker.sv
module fetch_exec_seq_checker #(
    parameter int unsigned PC_W = 21,
    parameter int unsigned IW   = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            br_take,
    input logic [PC_W-1:0] br_target,
    input logic [PC_W-1:0] pm_addr,
    input logic [IW-1:0]   instr_reg,
    input logic [3:0]      q_strobe,
    input logic            clk_out,
    input logic            dm_rd,
    input logic            dm_wr,
    input logic            bubble
);
    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(q_strobe) == 1);
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        q_strobe[3] |=> q_strobe[0]);
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        q_strobe[0] |=> q_strobe[1]);
    a_r2_clkout: assert property (@(posedge clk) disable iff (rst)
        clk_out == (q_strobe[0] | q_strobe[1]));
    a_r3_even: assert property (@(posedge clk) disable iff (rst)
        pm_addr[0] == 1'b0);
    a_r3_stable: assert property (@(posedge clk) disable iff (rst)
        !q_strobe[3] |=> $stable(pm_addr));
    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (q_strobe[3] && !(br_take && !bubble))
        |=> pm_addr == PC_W'($past(pm_addr) + PC_W'(2)));
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !q_strobe[3] |=> $stable(instr_reg) && $stable(bubble));
    a_r5_read: assert property (@(posedge clk) disable iff (rst)
        dm_rd |-> q_strobe[1] && !bubble);
    a_r5_write: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> q_strobe[3] && !bubble);
    a_r7_redirect: assert property (@(posedge clk) disable iff (rst)
        (q_strobe[3] && br_take && !bubble)
        |=> bubble && instr_reg == '0
            && pm_addr == {$past(br_target[PC_W-1:1]), 1'b0});
endmodule

bind fetch_exec_seq fetch_exec_seq_checker #(.PC_W(PC_W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .br_take   (br_take),
    .br_target (br_target),
    .pm_addr   (pm_addr),
    .instr_reg (instr_reg),
    .q_strobe  (q_strobe),
    .clk_out   (clk_out),
    .dm_rd     (dm_rd),
    .dm_wr     (dm_wr),
    .bubble    (bubble)
);

// File: tb/fetch_exec_seq_test.sv
module fetch_exec_seq_test;
    localparam int PW = 21;
    localparam logic [PW-1:0] TOP_ADDR = 21'h1FFFFE;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [PW-1:0] pm_addr;
    logic [15:0]   pm_data;
    logic [15:0]   instr_reg;
    logic [3:0]    q_strobe;
    logic          clk_out, dm_rd, dm_wr, bubble;
    logic          br_take = 1'b0;
    logic [PW-1:0] br_target = '0;

    always #4 clk = ~clk;

    fetch_exec_seq uut (
        .clk       (clk),
        .rst       (rst),
        .pm_data   (pm_data),
        .br_take   (br_take),
        .br_target (br_target),
        .pm_addr   (pm_addr),
        .instr_reg (instr_reg),
        .q_strobe  (q_strobe),
        .clk_out   (clk_out),
        .dm_rd     (dm_rd),
        .dm_wr     (dm_wr),
        .bubble    (bubble)
    );

    function automatic logic [15:0] word_at(logic [PW-1:0] a);
        return a[16:1] ^ 16'h3C5A;
    endfunction

    assign pm_data = word_at(pm_addr);

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    logic [PW-1:0] exp_pc;
    logic [15:0]   exp_ir;
    logic          exp_bub;
    string         ctx;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        exp_pc  = '0;
        exp_ir  = 16'h0000;
        exp_bub = 1'b1;
        ctx     = "R6";
    endtask

    function automatic logic [PW-1:0] tgt_of(int k);
        if (k == 12) return 21'h1FFFFF;         // odd, lands on top address
        return PW'(k * 32'h0001F3A7);
    endfunction

    // One instruction cycle: checks at each phase, then inputs for that phase.
    task automatic run_cycle(int k);
        for (int p = 0; p < 4; p++) begin
            chk("R1 q_strobe", q_strobe, 32'(4'b0001 << p));
            chk("R2 clk_out", clk_out, p < 2);
            chk({ctx, " pm_addr"}, pm_addr, exp_pc);
            chk({ctx, " instr_reg"}, instr_reg, exp_ir);
            chk({ctx, " R9 bubble"}, bubble, exp_bub);
            chk("R5 dm_rd", dm_rd, (p == 1) && !exp_bub);
            chk("R5 dm_wr", dm_wr, (p == 3) && !exp_bub);

            br_take = 1'b0;
            if (p == 3) begin
                if (exp_bub) begin
                    br_take   = 1'b1;             // R8: bubble may not branch
                    br_target = PW'(k * 32'h00000777);
                end else if (k % 5 == 2) begin
                    br_take   = 1'b1;
                    br_target = tgt_of(k);
                end
            end else if (k % 3 == 0) begin
                br_take   = 1'b1;                 // R8: wrong phase
                br_target = PW'(32'h00ABCDE + k);
            end

            if (p == 3) begin
                if (br_take && !exp_bub) begin
                    exp_pc  = {br_target[PW-1:1], 1'b0};
                    exp_ir  = 16'h0000;
                    exp_bub = 1'b1;
                    ctx     = "R7";
                end else begin
                    exp_ir  = word_at(exp_pc);
                    exp_bub = 1'b0;
                    ctx     = br_take ? "R8" : ((exp_pc == TOP_ADDR) ? "R10" : "R3 R4");
                    exp_pc  = exp_pc + PW'(2);
                end
            end else if (br_take) begin
                ctx = "R8";
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int k = 0; k < 400; k++) begin
            if (k == 200) begin
                rst = 1'b1;
                br_take = 1'b0;
                repeat (2) @(negedge clk);
                rst = 1'b0;
                model_reset();
            end
            run_cycle(k);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule